// File: doc/BRIEF.md
# Two-Area Ping-Pong Audio Fetch Sequencer

This block generates the memory addresses for one audio channel. Software programs two memory areas, each with its own start address and byte length. While the block is running it offers one fetch address at a time on a valid/ready handshake. Each fetch the consumer accepts moves the position forward by one frame. A frame is 1, 2 or 4 bytes, set by the sample width and the channel count in the format register. When an area is used up, the block raises that area's completion flag and continues with the other area. It keeps alternating between the two areas until software stops it.

Software reaches the block through a small word-indexed register port. Writes take effect on the clock edge. Reads are combinational from the register index. Completion flags are cleared by writing 1s back to the status word. The channel interrupt is high while either flag is still set.

Top module: `audio_dma_pingpong`

## Requirements
- R1: After reset every register reads zero except the format word, which reads 0x0010. `fetch_valid` and `irq` are low.
- R2: Control word (index 0) keeps bits 5:0 as written, and bits 31:6 read zero. Bit 0 is the run bit: `fetch_valid` is high exactly while it is set.
- R3: `fetch_addr` and the position word (index 5) both equal the start address of the active area (index 2 for area A, index 3 for area B) plus the current offset. Writes to indices 5 and 6 have no effect.
- R4: Each cycle with `fetch_valid` and `fetch_ready` both high adds the frame size to the offset (index 6, bits 15:0). Format bit 4 selects 16-bit samples and bit 5 selects stereo. The frame size is 1 byte for 8-bit mono, 2 bytes for 16-bit mono or 8-bit stereo, and 4 bytes for 16-bit stereo. With `fetch_ready` low the offset does not change.
- R5: If an accepted fetch would bring the offset to or past the active area's length, on that same edge the offset returns to 0, the other area becomes active and the finished area's flag is set. Area A is active after reset.
- R6: In the status word (index 1), bit 1 is area A finished and bit 2 is area B finished. All other status bits read zero. Writing 1 to a flag bit clears it, and writing 0xFFFF clears both. If a flag is set and acknowledged on the same edge, it ends up set.
- R7: `irq` is the OR of the two status flags.
- R8: While the run bit is clear, the offset and the active area hold their values. Setting the run bit again continues from the same position.
- R9: Format word (index 7) keeps bits 5:0 as written, and bits 31:6 read zero. Bits 3:0 hold the rate code and do not affect fetching.
- R10: The length word (index 4) holds the area A length in bits 15:0 and the area B length in bits 31:16, both in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fetch_valid | output | 1 | A fetch address is offered |
| fetch_ready | input | 1 | Consumer accepts the offered address |
| fetch_addr | output | 32 | Byte address of the current frame |
| irq | output | 1 | Channel interrupt |

## Verification
An area can finish on the same edge that software acknowledges that area's flag. The bench provokes this by steering the offset to the last frame of area B and then writing the acknowledge in the cycle the final fetch is accepted. It judges the result by reading the status word and `irq` afterwards: the new completion must not be lost. Random traffic also mixes format, length and run-bit writes with accepted fetches in the same cycle. A reference model that applies the old settings to the fetch and the new settings afterwards checks every cycle.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  localparam int LEN_W = 16;
  localparam int REG_DW = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] IDX_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] IDX_STATUS = 3'd1;
  localparam logic [REG_AW-1:0] IDX_BASE_A = 3'd2;
  localparam logic [REG_AW-1:0] IDX_BASE_B = 3'd3;
  localparam logic [REG_AW-1:0] IDX_LENS   = 3'd4;
  localparam logic [REG_AW-1:0] IDX_POS    = 3'd5;
  localparam logic [REG_AW-1:0] IDX_OFS    = 3'd6;
  localparam logic [REG_AW-1:0] IDX_FMT    = 3'd7;

  localparam logic [5:0] FMT_RESET = 6'h10;

  // bytes per frame: 1 shifted by (wide + stereo)
  function automatic logic [2:0] frame_bytes(input logic wide, input logic stereo);
    logic [1:0] sh;
    sh = {1'b0, wide} + {1'b0, stereo};
    return 3'd1 << sh;
  endfunction

  // offset after one frame, one bit wider so it cannot wrap
  function automatic logic [LEN_W:0] advance(input logic [LEN_W-1:0] ofs, input logic [2:0] step);
    return {1'b0, ofs} + (LEN_W+1)'(step);
  endfunction
endpackage

// File: rtl/dma_pp_walker.sv
module dma_pp_walker
  import dma_pp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wide,
  input  logic              stereo,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] start_b,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  input  logic              fetch_ready,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LEN_W-1:0]  offset,
  output logic              done_a,
  output logic              done_b
);
  logic             area_q;   // 0 = area A, 1 = area B
  logic [LEN_W-1:0] ofs_q;
  logic             accept;
  logic             wrap;
  logic [2:0]       step;
  logic [LEN_W:0]   nxt;
  logic [LEN_W-1:0] len_cur;

  always_comb begin
    step    = frame_bytes(wide, stereo);
    nxt     = advance(ofs_q, step);
    len_cur = area_q ? len_b : len_a;
    accept  = run && fetch_ready;
    wrap    = accept && (nxt >= {1'b0, len_cur});
    done_a  = wrap && !area_q;
    done_b  = wrap && area_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_q <= 1'b0;
      ofs_q  <= '0;
    end else if (wrap) begin
      area_q <= !area_q;
      ofs_q  <= '0;
    end else if (accept) begin
      ofs_q  <= nxt[LEN_W-1:0];
    end
  end

  assign fetch_valid = run;
  assign fetch_addr  = (area_q ? start_b : start_a) + ADDR_W'(ofs_q);
  assign offset      = ofs_q;

  assert_one_area_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_a, done_b}));
  assert_switch_to_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_a |=> (area_q && ofs_q == '0));
  assert_switch_to_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_b |=> (!area_q && ofs_q == '0));
  assert_hold_when_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(ofs_q) && $stable(area_q)));
  assert_hold_without_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |=> ($stable(ofs_q) && $stable(area_q)));
endmodule

// File: rtl/dma_pp_regs.sv
module dma_pp_regs
  import dma_pp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              done_a,
  input  logic              done_b,
  input  logic [ADDR_W-1:0] pos,
  input  logic [LEN_W-1:0]  ofs,
  output logic              run,
  output logic              wide,
  output logic              stereo,
  output logic [ADDR_W-1:0] start_a,
  output logic [ADDR_W-1:0] start_b,
  output logic [LEN_W-1:0]  len_a,
  output logic [LEN_W-1:0]  len_b,
  output logic              flag_a,
  output logic              flag_b
);
  logic [5:0] ctrl_q;
  logic [5:0] fmt_q;
  logic       ack_a;
  logic       ack_b;

  assign ack_a = wr_en && addr == IDX_STATUS && wdata[1];
  assign ack_b = wr_en && addr == IDX_STATUS && wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fmt_q   <= FMT_RESET;
      start_a <= '0;
      start_b <= '0;
      len_a   <= '0;
      len_b   <= '0;
      flag_a  <= 1'b0;
      flag_b  <= 1'b0;
    end else begin
      // a fresh completion takes priority over an acknowledge
      flag_a <= done_a || (flag_a && !ack_a);
      flag_b <= done_b || (flag_b && !ack_b);
      if (wr_en) begin
        case (addr)
          IDX_CTRL:   ctrl_q  <= wdata[5:0];
          IDX_BASE_A: start_a <= ADDR_W'(wdata);
          IDX_BASE_B: start_b <= ADDR_W'(wdata);
          IDX_LENS: begin
            len_a <= wdata[LEN_W-1:0];
            len_b <= wdata[2*LEN_W-1:LEN_W];
          end
          IDX_FMT:    fmt_q   <= wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  assign run    = ctrl_q[0];
  assign wide   = fmt_q[4];
  assign stereo = fmt_q[5];

  always_comb begin
    case (addr)
      IDX_CTRL:   rdata = {26'd0, ctrl_q};
      IDX_STATUS: rdata = {29'd0, flag_b, flag_a, 1'b0};
      IDX_BASE_A: rdata = REG_DW'(start_a);
      IDX_BASE_B: rdata = REG_DW'(start_b);
      IDX_LENS:   rdata = {len_b, len_a};
      IDX_POS:    rdata = REG_DW'(pos);
      IDX_OFS:    rdata = REG_DW'(ofs);
      default:    rdata = {26'd0, fmt_q};
    endcase
  end

  assert_done_a_not_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_a |=> flag_a);
  assert_done_b_not_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_b |=> flag_b);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_a && !done_a) |=> !flag_a);
endmodule

// File: rtl/audio_dma_pingpong.sv
module audio_dma_pingpong
  import dma_pp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              irq
);
  logic              run, wide, stereo;
  logic [ADDR_W-1:0] start_a, start_b;
  logic [LEN_W-1:0]  len_a, len_b, offset;
  logic              done_a, done_b;
  logic              flag_a, flag_b;

  dma_pp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .done_a(done_a), .done_b(done_b),
    .pos(fetch_addr), .ofs(offset), .run(run), .wide(wide), .stereo(stereo),
    .start_a(start_a), .start_b(start_b), .len_a(len_a), .len_b(len_b),
    .flag_a(flag_a), .flag_b(flag_b)
  );

  dma_pp_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .run(run), .wide(wide), .stereo(stereo),
    .start_a(start_a), .start_b(start_b), .len_a(len_a), .len_b(len_b),
    .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .offset(offset), .done_a(done_a), .done_b(done_b)
  );

  assign irq = flag_a || flag_b;

  assert_irq_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_a || done_b));
endmodule

// File: tb/audio_dma_pingpong_bench.sv
module audio_dma_pingpong_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model
  logic [5:0]  m_ctrl = 6'h00;
  logic [5:0]  m_fmt = 6'h10;
  logic [31:0] m_sa = '0, m_sb = '0;
  logic [15:0] m_la = '0, m_lb = '0, m_ofs = '0;
  logic        m_area = 1'b0, m_fa = 1'b0, m_fb = 1'b0;

  audio_dma_pingpong u_audio_dma_pingpong (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int frame_of(input logic [5:0] f);
    int b;
    b = f[4] ? 2 : 1;
    if (f[5]) b = b * 2;
    return b;
  endfunction

  function automatic logic [31:0] model_pos();
    return (m_area ? m_sb : m_sa) + {16'd0, m_ofs};
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {26'd0, m_ctrl};
      3'd1: return {29'd0, m_fb, m_fa, 1'b0};
      3'd2: return m_sa;
      3'd3: return m_sb;
      3'd4: return {m_lb, m_la};
      3'd5: return model_pos();
      3'd6: return {16'd0, m_ofs};
      default: return {26'd0, m_fmt};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R6";
      3'd4: return "R10";
      3'd6: return "R4";
      3'd7: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic rdy);
    int st;
    logic [16:0] nx;
    logic [15:0] lc;
    logic da, db, acka, ackb;
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; fetch_ready = rdy;
    st = frame_of(m_fmt);
    lc = m_area ? m_lb : m_la;
    da = 1'b0; db = 1'b0;
    @(posedge clk);
    if (m_ctrl[0] && rdy) begin
      nx = {1'b0, m_ofs} + 17'(st);
      if (nx >= {1'b0, lc}) begin
        if (m_area) db = 1'b1; else da = 1'b1;
        m_area = !m_area;
        m_ofs = '0;
      end else m_ofs = nx[15:0];
    end
    acka = wr && a == 3'd1 && d[1];
    ackb = wr && a == 3'd1 && d[2];
    m_fa = da || (m_fa && !acka);
    m_fb = db || (m_fb && !ackb);
    if (wr) begin
      case (a)
        3'd0: m_ctrl = d[5:0];
        3'd2: m_sa = d;
        3'd3: m_sb = d;
        3'd4: begin m_la = d[15:0]; m_lb = d[31:16]; end
        3'd7: m_fmt = d[5:0];
        default: ;
      endcase
    end
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R2", {31'd0, fetch_valid}, {31'd0, m_ctrl[0]});
    chk("R3", fetch_addr, model_pos());
    chk("R7", {31'd0, irq}, {31'd0, m_fa || m_fb});
    if (!wr) chk(tag_of(a), reg_rdata, model_read(a));
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      reg_addr = 3'(i);
      #1;
      chk("R1", reg_rdata, (i == 7) ? 32'h10 : 32'h0);
    end
    chk("R1", {30'd0, fetch_valid, irq}, 32'd0);

    // R2, R9: writable widths
    cyc(1, 3'd7, 32'hFFFF_FFFF, 0); cyc(0, 3'd7, 0, 0);
    chk("R9", reg_rdata, 32'h3F);
    cyc(1, 3'd0, 32'hFFFF_FFFE, 1); cyc(0, 3'd0, 0, 1);
    chk("R2", reg_rdata, 32'h3E);

    // setup: A at 0x1000 len 4, B at 0x2000 len 6, 16-bit mono
    cyc(1, 3'd2, 32'h1000, 0);
    cyc(1, 3'd3, 32'h2000, 0);
    cyc(1, 3'd4, {16'd6, 16'd4}, 0);
    cyc(0, 3'd4, 0, 0);
    chk("R10", reg_rdata, 32'h0006_0004);
    cyc(1, 3'd7, 32'h10, 0);
    cyc(1, 3'd0, 32'h1, 0);
    cyc(0, 3'd6, 0, 1);
    chk("R4", fetch_addr, 32'h1002);
    cyc(0, 3'd1, 0, 1);   // wraps out of A
    chk("R5", reg_rdata, 32'h2);
    chk("R5", fetch_addr, 32'h2000);
    // R3: position/offset words ignore writes
    cyc(1, 3'd5, 32'hDEAD, 0); cyc(1, 3'd6, 32'hBEEF, 0);
    cyc(0, 3'd5, 0, 0);
    chk("R3", reg_rdata, 32'h2000);

    // R6: same-edge completion and acknowledge of area B
    while (!(m_area && (m_ofs + 16'(frame_of(m_fmt)) >= m_lb))) cyc(0, 3'd6, 0, 1);
    cyc(1, 3'd1, 32'h4, 1);
    cyc(0, 3'd1, 0, 0);
    chk("R6", reg_rdata, 32'h6);
    chk("R7", {31'd0, irq}, 32'd1);
    cyc(1, 3'd1, 32'hFFFF, 0);
    cyc(0, 3'd1, 0, 0);
    chk("R6", reg_rdata, 32'h0);
    chk("R7", {31'd0, irq}, 32'd0);

    // R8: pause holds position, resume continues
    cyc(0, 3'd6, 0, 1);
    cyc(1, 3'd0, 32'h0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 3'd6, 0, 1);
    chk("R8", reg_rdata, {16'd0, m_ofs});
    cyc(1, 3'd0, 32'h1, 1);
    cyc(0, 3'd5, 0, 1);

    // R4: frame sizes per format, long area
    cyc(1, 3'd4, {16'd400, 16'd400}, 0);
    for (int f = 0; f < 4; f++) begin
      cyc(1, 3'd7, {26'd0, 2'(f), 4'(f * 3)}, 0);
      for (int k = 0; k < 6; k++) cyc(0, 3'd6, 0, 1);
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      logic rdy;
      rdy = ($urandom % 4) != 0;
      a = 3'($urandom % 8);
      d = $urandom;
      if (($urandom % 8) == 0) begin
        if (a == 3'd4) d = d & 32'h003F_003F;
        if (a == 3'd0) d[0] = ($urandom % 4) != 0;
        cyc(1, a, d, rdy);
      end else cyc(0, a, 0, rdy);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule